// File: doc/BRIEF.md
# I2C Clock-Line Bit-Rate Generator

This block times the clock line of an I2C master. A prescaler divides the functional clock by `psc_i + 1` to make an internal sampling tick. Each bit period has a low phase of (low setting + 7) ticks followed by a high phase of (high setting + 5) ticks. A bit period therefore lasts `(psc_i+1)·(low+7+high+5)` functional clocks. For example, a 48 MHz clock with divider 1 and settings 111/117 gives 100 kHz.

Each of the two 16-bit phase inputs holds two values. The lower byte holds the standard/fast setting. The upper byte holds the high-speed setting, which is used only while `hs_mode_i` is set.

The bit engine holds `bit_req_i` high to ask for bit periods. The block answers with the clock level and with one-cycle strobes at each clock-line edge.

The controller is a four-state machine:
- **OFF**: disabled; the line is released and the counters are cleared.
- **IDLE**: enabled; the line is high and no bit is in progress.
- **LOW**: low phase of a bit.
- **HIGH**: high phase of a bit.

Transitions:
- *wake*: OFF→IDLE, when enabled.
- *start*: IDLE→LOW, when a request is present.
- *low_end*: LOW→HIGH, on the last tick of the low phase.
- *chain*: HIGH→LOW, on the last high tick when the request is still present.
- *park*: HIGH→IDLE, on the last high tick with no request.
- *drop*: any state→OFF, when enable falls.

The divider, both phase settings and the mode bit are captured on *start* and *chain* only.

Top module: `sclk_rate_gen`

## Requirements
- R1: After reset, `scl_o` is 1 and `rise_o`, `fall_o` and `tick_o` are 0.
- R2: While enabled, `tick_o` pulses once every `psc_i+1` clock cycles. In IDLE the live `psc_i` value sets this rate.
- R3: With `hs_mode_i`=0, SCL stays low for `(low_cfg_i[7:0]+7)·(psc_i+1)` clock cycles per bit.
- R4: With `hs_mode_i`=0, SCL stays high for `(high_cfg_i[7:0]+5)·(psc_i+1)` clock cycles between two chained bits.
- R5: With `hs_mode_i`=1, the phase lengths use `low_cfg_i[15:8]` and `high_cfg_i[15:8]` in place of the lower bytes.
- R6: `fall_o` is high for exactly the first cycle in which SCL is low. `rise_o` is high for exactly the first cycle in which SCL is high. The two are never high together.
- R7: If `bit_req_i` is high at the last high tick, the next bit starts at once. Otherwise SCL stays high and no further strobe appears. Every `fall_o` follows a cycle in which `bit_req_i` was high.
- R8: Changes to `psc_i`, the phase inputs or `hs_mode_i` during a bit do not alter that bit. They apply from the next bit start.
- R9: With `enable_i` low, SCL is high from the next cycle, no tick or strobe appears, and `bit_req_i` is ignored. After re-enabling, the first bit has full-length phases.
- R10: When `bit_req_i` is high in IDLE, `fall_o` and the low level appear in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Functional clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Block enable; low releases SCL and clears counters |
| hs_mode_i | input | 1 | Selects the upper-byte high-speed phase settings |
| bit_req_i | input | 1 | Request to run bit periods |
| psc_i | input | DIV_W (8) | Prescaler setting; tick every psc_i+1 cycles |
| low_cfg_i | input | 2·PH_W (16) | Low-phase setting: [7:0] normal, [15:8] high-speed |
| high_cfg_i | input | 2·PH_W (16) | High-phase setting: [7:0] normal, [15:8] high-speed |
| scl_o | output | 1 | Generated clock-line level |
| tick_o | output | 1 | Internal sampling tick |
| rise_o | output | 1 | One-cycle strobe at SCL low-to-high |
| fall_o | output | 1 | One-cycle strobe at SCL high-to-low |

## Verification
The checks assume that every input is synchronous to `clk_i` and free of X after reset. They place no limit on when the configuration inputs or the request may change. The minimum-low-time check relies on the fixed offset of seven ticks, which no setting can shorten.

The stimulus changes inputs only on the falling clock edge, so they are stable at every active edge. It changes configuration in the middle of a bit on purpose, to show that the captured values hold. It removes the request only after a strobe has been seen, so each decision point sees a defined request.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

    // Controller states of the bit-rate generator.
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_IDLE = 2'd1,
        ST_LOW  = 2'd2,
        ST_HIGH = 2'd3
    } sclk_state_e;

    // Fixed tick offsets added in hardware to the programmed phase values.
    localparam int unsigned SCLK_LOW_ADD  = 7;
    localparam int unsigned SCLK_HIGH_ADD = 5;

endpackage

// File: rtl/sclk_cfg_latch.sv
module sclk_cfg_latch #(
    parameter int unsigned DIV_W = 8,
    parameter int unsigned PH_W  = 8,
    parameter int unsigned CNT_W = PH_W + 1,
    parameter bit          HS_EN = 1'b1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               load_i,
    input  logic               hs_mode_i,
    input  logic [DIV_W-1:0]   psc_i,
    input  logic [2*PH_W-1:0]  low_cfg_i,
    input  logic [2*PH_W-1:0]  high_cfg_i,
    output logic [DIV_W-1:0]   div_o,
    output logic [CNT_W-1:0]   low_last_o,
    output logic [CNT_W-1:0]   high_last_o
);
    import sclk_pkg::*;

    localparam logic [CNT_W-1:0] LOW_TERM  = CNT_W'(SCLK_LOW_ADD - 1);
    localparam logic [CNT_W-1:0] HIGH_TERM = CNT_W'(SCLK_HIGH_ADD - 1);

    logic [PH_W-1:0] low_sel;
    logic [PH_W-1:0] high_sel;

    // Pick which byte of each phase input feeds the counters.
    generate
        if (HS_EN) begin : g_hs
            assign low_sel  = hs_mode_i ? low_cfg_i[2*PH_W-1:PH_W]  : low_cfg_i[PH_W-1:0];
            assign high_sel = hs_mode_i ? high_cfg_i[2*PH_W-1:PH_W] : high_cfg_i[PH_W-1:0];
        end else begin : g_std
            assign low_sel  = low_cfg_i[PH_W-1:0];
            assign high_sel = high_cfg_i[PH_W-1:0];
        end
    endgenerate

    // Capture terminal counts only at a bit start.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            div_o       <= '0;
            low_last_o  <= LOW_TERM;
            high_last_o <= HIGH_TERM;
        end else if (load_i) begin
            div_o       <= psc_i;
            low_last_o  <= CNT_W'(low_sel) + LOW_TERM;
            high_last_o <= CNT_W'(high_sel) + HIGH_TERM;
        end
    end

endmodule

// File: rtl/sclk_prescaler.sv
module sclk_prescaler #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] cnt_q;

    // Greater-or-equal keeps the divider safe when div_i shrinks under the count.
    assign tick_o = run_i && (cnt_q >= div_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (!run_i || restart_i || tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/sclk_phase_fsm.sv
module sclk_phase_fsm #(
    parameter int unsigned CNT_W = 9
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             enable_i,
    input  logic             bit_req_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] low_last_i,
    input  logic [CNT_W-1:0] high_last_i,
    output logic             load_o,
    output logic             in_bit_o,
    output logic             scl_o,
    output logic             rise_o,
    output logic             fall_o
);
    import sclk_pkg::*;

    sclk_state_e      state_q;
    sclk_state_e      state_d;
    logic [CNT_W-1:0] ph_q;
    logic             low_end;
    logic             high_end;
    logic             in_phase;

    assign in_phase = (state_q == ST_LOW) || (state_q == ST_HIGH);
    assign in_bit_o = in_phase;
    assign low_end  = tick_i && (ph_q == low_last_i);
    assign high_end = tick_i && (ph_q == high_last_i);

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        load_o  = 1'b0;
        if (!enable_i) begin
            state_d = ST_OFF;                       // drop
        end else begin
            unique case (state_q)
                ST_OFF:  state_d = ST_IDLE;         // wake
                ST_IDLE: begin
                    if (bit_req_i) begin            // start
                        state_d = ST_LOW;
                        load_o  = 1'b1;
                    end
                end
                ST_LOW: begin
                    if (low_end) begin
                        state_d = ST_HIGH;          // low_end
                    end
                end
                ST_HIGH: begin
                    if (high_end) begin
                        if (bit_req_i) begin        // chain
                            state_d = ST_LOW;
                            load_o  = 1'b1;
                        end else begin              // park
                            state_d = ST_IDLE;
                        end
                    end
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    // State register and tick counter within the current phase.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_OFF;
            ph_q    <= '0;
        end else begin
            state_q <= state_d;
            if ((state_d != state_q) || load_o) begin
                ph_q <= '0;
            end else if (tick_i && in_phase) begin
                ph_q <= ph_q + 1'b1;
            end
        end
    end

    // Registered outputs derived from the next state.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            scl_o  <= 1'b1;
            rise_o <= 1'b0;
            fall_o <= 1'b0;
        end else begin
            scl_o  <= (state_d != ST_LOW);
            rise_o <= (state_q == ST_LOW) && (state_d == ST_HIGH);
            fall_o <= load_o;
        end
    end

endmodule

// File: rtl/sclk_rate_gen.sv
module sclk_rate_gen #(
    parameter int unsigned DIV_W = 8,
    parameter int unsigned PH_W  = 8,
    parameter bit          HS_EN = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              enable_i,
    input  logic              hs_mode_i,
    input  logic              bit_req_i,
    input  logic [DIV_W-1:0]  psc_i,
    input  logic [2*PH_W-1:0] low_cfg_i,
    input  logic [2*PH_W-1:0] high_cfg_i,
    output logic              scl_o,
    output logic              tick_o,
    output logic              rise_o,
    output logic              fall_o
);

    localparam int unsigned CNT_W = PH_W + 1;

    logic             load;
    logic             in_bit;
    logic             tick;
    logic [DIV_W-1:0] div_lat;
    logic [DIV_W-1:0] div_use;
    logic [CNT_W-1:0] low_last;
    logic [CNT_W-1:0] high_last;

    // Between bits the live divider runs the tick; inside a bit the captured one does.
    assign div_use = in_bit ? div_lat : psc_i;
    assign tick_o  = tick;

    sclk_cfg_latch #(
        .DIV_W (DIV_W),
        .PH_W  (PH_W),
        .CNT_W (CNT_W),
        .HS_EN (HS_EN)
    ) u_cfg (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .load_i      (load),
        .hs_mode_i   (hs_mode_i),
        .psc_i       (psc_i),
        .low_cfg_i   (low_cfg_i),
        .high_cfg_i  (high_cfg_i),
        .div_o       (div_lat),
        .low_last_o  (low_last),
        .high_last_o (high_last)
    );

    sclk_prescaler #(
        .DIV_W (DIV_W)
    ) u_psc (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (enable_i),
        .restart_i (load),
        .div_i     (div_use),
        .tick_o    (tick)
    );

    sclk_phase_fsm #(
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .enable_i    (enable_i),
        .bit_req_i   (bit_req_i),
        .tick_i      (tick),
        .low_last_i  (low_last),
        .high_last_i (high_last),
        .load_o      (load),
        .in_bit_o    (in_bit),
        .scl_o       (scl_o),
        .rise_o      (rise_o),
        .fall_o      (fall_o)
    );

endmodule

// File: rtl/sclk_rate_gen_chk.sv
module sclk_rate_gen_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic enable_i,
    input logic bit_req_i,
    input logic scl_o,
    input logic tick_o,
    input logic rise_o,
    input logic fall_o
);

    logic [15:0] lowrun;

    // Consecutive cycles with the clock line low.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lowrun <= '0;
        end else if (scl_o) begin
            lowrun <= '0;
        end else if (lowrun != 16'hFFFF) begin
            lowrun <= lowrun + 1'b1;
        end
    end

    // R6: every falling clock edge is announced by the fall strobe
    a_r6_fall_marks_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(scl_o) |-> fall_o);

    // R6: the rise strobe appears only in the first high cycle
    a_r6_rise_marks_lift: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |-> (scl_o && !$past(scl_o)));

    // R6: the two strobes never coincide
    a_r6_strobes_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({rise_o, fall_o}));

    // R7: a new bit needs a request in the cycle before
    a_r7_fall_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fall_o |-> $past(bit_req_i));

    // R9: disabling releases the line and silences the strobes
    a_r9_off_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !enable_i |=> (scl_o && !rise_o && !fall_o));

    // R9: no tick while disabled
    a_r9_off_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !enable_i |-> !tick_o);

    // R3: a completed low phase is never shorter than the fixed seven ticks
    a_r3_min_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |-> (lowrun >= 16'd7));

endmodule

bind sclk_rate_gen sclk_rate_gen_chk u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .enable_i  (enable_i),
    .bit_req_i (bit_req_i),
    .scl_o     (scl_o),
    .tick_o    (tick_o),
    .rise_o    (rise_o),
    .fall_o    (fall_o)
);

// File: tb/sclk_rate_gen_tb_top.sv
`timescale 1ns/1ps
module sclk_rate_gen_tb_top;

    localparam int LIMIT = 1500;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        hs_mode = 1'b0;
    logic        bit_req = 1'b0;
    logic [7:0]  psc = 8'd0;
    logic [15:0] low_cfg = 16'd0;
    logic [15:0] high_cfg = 16'd0;
    logic        scl_o, tick_o, rise_o, fall_o;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    sclk_rate_gen dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .enable_i   (enable),
        .hs_mode_i  (hs_mode),
        .bit_req_i  (bit_req),
        .psc_i      (psc),
        .low_cfg_i  (low_cfg),
        .high_cfg_i (high_cfg),
        .scl_o      (scl_o),
        .tick_o     (tick_o),
        .rise_o     (rise_o),
        .fall_o     (fall_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Starting at a sample with fall_o high: count low cycles, then high cycles
    // until the next fall strobe or LIMIT.
    task automatic meas(output int lowc, output int highc, output int rise_seen,
                        output int fall_width);
        lowc = 0; highc = 0; fall_width = 0;
        while (scl_o == 1'b0 && lowc < LIMIT) begin
            lowc++;
            if (fall_o) fall_width++;
            @(negedge clk);
        end
        rise_seen = int'(rise_o);
        while (!fall_o && highc < LIMIT) begin
            highc++;
            @(negedge clk);
        end
    endtask

    // Two bits: the first chained into the second, the second parks in idle.
    task automatic run_case(input string nm, input logic [7:0] p, input logic [15:0] lc,
                            input logic [15:0] hc, input logic hs,
                            input int exp_lo, input int exp_hi);
        int l, h, r, fw;
        psc = p; low_cfg = lc; high_cfg = hc; hs_mode = hs;
        @(negedge clk);
        bit_req = 1'b1;
        @(negedge clk);
        chk({nm, " R10 fall one cycle after request"}, int'(fall_o), 1);
        chk({nm, " R10 line low at start"}, int'(scl_o), 0);
        meas(l, h, r, fw);
        bit_req = 1'b0;
        chk({nm, " R3 low length"}, l, exp_lo);
        chk({nm, " R4 high length"}, h, exp_hi);
        chk({nm, " R6 rise strobe at first high"}, r, 1);
        chk({nm, " R6 fall strobe width"}, fw, 1);
        meas(l, h, r, fw);
        chk({nm, " R3 second low length"}, l, exp_lo);
        chk({nm, " R7 parks with no further fall"}, h, LIMIT);
        chk({nm, " R7 line stays high in idle"}, int'(scl_o), 1);
    endtask

    task automatic t_reset();
        chk("R1 scl after reset", int'(scl_o), 1);
        chk("R1 rise after reset", int'(rise_o), 0);
        chk("R1 fall after reset", int'(fall_o), 0);
        chk("R1 tick after reset", int'(tick_o), 0);
    endtask

    task automatic t_tick();
        int n;
        enable = 1'b1; psc = 8'd3;
        repeat (8) @(negedge clk);
        n = 0;
        for (int i = 0; i < 40; i++) begin
            if (tick_o) n++;
            @(negedge clk);
        end
        chk("R2 tick rate psc=3", n, 10);
        psc = 8'd0;
        repeat (4) @(negedge clk);
        n = 0;
        for (int i = 0; i < 20; i++) begin
            if (tick_o) n++;
            @(negedge clk);
        end
        chk("R2 tick rate psc=0", n, 20);
    endtask

    task automatic t_update();
        int l, h, r, fw;
        psc = 8'd1; low_cfg = 16'h0002; high_cfg = 16'h0001; hs_mode = 1'b0;
        @(negedge clk);
        bit_req = 1'b1;
        @(negedge clk);
        // change everything during the first bit
        psc = 8'd0; low_cfg = 16'h000A; high_cfg = 16'h0004;
        meas(l, h, r, fw);
        chk("R8 first low unchanged", l, 18);
        chk("R8 first high unchanged", h, 12);
        meas(l, h, r, fw);
        bit_req = 1'b0;
        chk("R8 second low uses new values", l, 17);
        chk("R8 second high uses new values", h, 9);
        meas(l, h, r, fw);
        chk("R8 third low", l, 17);
        chk("R7 update case parks", h, LIMIT);
    endtask

    task automatic t_disable();
        int bad;
        psc = 8'd1; low_cfg = 16'h0005; high_cfg = 16'h0007; hs_mode = 1'b0;
        @(negedge clk);
        bit_req = 1'b1;
        repeat (6) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk("R9 line released after disable", int'(scl_o), 1);
        chk("R9 no rise on disable", int'(rise_o), 0);
        chk("R9 no tick while disabled", int'(tick_o), 0);
        bad = 0;
        for (int i = 0; i < 10; i++) begin
            if (fall_o || rise_o || tick_o || !scl_o) bad++;
            @(negedge clk);
        end
        chk("R9 request ignored while disabled", bad, 0);
        bit_req = 1'b0;
        enable = 1'b1;
        repeat (3) @(negedge clk);
        run_case("R9 re-enable", 8'd1, 16'h0005, 16'h0007, 1'b0, 24, 24);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_tick();
        run_case("std", 8'd1, 16'h2005, 16'h3007, 1'b0, 24, 24);
        run_case("min", 8'd0, 16'hFF00, 16'hFF00, 1'b0, 7, 5);
        run_case("R5 hs", 8'd2, 16'h0309, 16'h0108, 1'b1, 30, 18);
        run_case("R5 hs ignored off", 8'd2, 16'h0309, 16'h0108, 1'b0, 48, 39);
        t_update();
        t_disable();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule